// File: doc/BRIEF.md
# Receive/Transmit FIFO Control with DMA Ready Pins

This block holds the transmit and receive byte queues of a serial port, the control register that configures them, and two active-low DMA request pins. A host loads the control register with one write. Bit 0 turns queueing on. The other fields set the DMA signalling style, empty either queue, and pick the receive threshold. Those other fields take effect only when bit 0 is set in the same write. With queueing off, each direction holds just one byte, and the DMA pins follow the per-character style.

Data enters and leaves each queue over valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. `*_in_ready` drops when the queue is at capacity, so a producer that keeps `valid` high is simply held off. Nothing is overwritten. `*_out_valid` is high whenever the queue holds at least one byte. `*_out_data` always shows the oldest byte, and when the queue is empty it still shows the last byte at the read position. A consumer raising `ready` while `valid` is low changes nothing. The counts, flags and DMA pins are plain status outputs that change on the edge after the handshake or write that caused them.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, queueing is off, the DMA style is per-character, the receive threshold is 1, both counts are 0, both empty flags are 1, `tx_rdy_n` is 0 and `rx_rdy_n` is 1.
- R2: A control write with bit 0 = 1 sets queueing on, loads the DMA style from bit 3 (0 per-character, 1 block) and loads the threshold select from bits 7:6. A write with bit 0 = 0 turns queueing off and leaves the style and the threshold select unchanged.
- R3: A write with bit 0 = 1 and bit 1 = 1 empties the receive queue. A write with bit 0 = 1 and bit 2 = 1 empties the transmit queue. The other queue is untouched, no flush state persists, and the next push is accepted normally.
- R4: Any control write that changes the bit-0 state empties both queues on that edge.
- R5: With queueing on, each queue holds up to 16 bytes in arrival order. The receive queue keeps filling past its threshold until it is full. At 16 bytes, `in_ready` is 0 and further pushes are dropped.
- R6: With queueing off, each queue holds at most one byte, and `in_ready` is 0 while that byte is present.
- R7: A pop with the queue empty leaves the count at 0, and `out_valid` stays 0.
- R8: Threshold select 00/01/10/11 gives 1/4/8/14 bytes. `rx_trig_hit` is 1 exactly when the receive count is at or above the threshold. The retained threshold also applies while queueing is off.
- R9: In per-character style, or whenever queueing is off, `tx_rdy_n` is 0 exactly when the transmit count is 0, and `rx_rdy_n` is 0 exactly when the receive count is nonzero.
- R10: In block style with queueing on, `tx_rdy_n` is 0 exactly when the transmit queue has a free slot.
- R11: In block style with queueing on, `rx_rdy_n` goes to 0 once the receive count reaches the threshold. It then stays 0 while any byte remains, and returns to 1 only when the queue is empty.
- R12: A flush and a push on the same edge leave the queue empty. A push and a pop on the same edge of a non-full queue keep the count unchanged and preserve the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| tx_in_valid | input | 1 | Host offers a byte to the transmit queue |
| tx_in_ready | output | 1 | Transmit queue can accept a byte |
| tx_in_data | input | 8 | Byte offered to the transmit queue |
| tx_out_valid | output | 1 | Transmit queue holds a byte |
| tx_out_ready | input | 1 | Shifter takes the oldest transmit byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| rx_in_valid | input | 1 | Shifter offers a received byte |
| rx_in_ready | output | 1 | Receive queue can accept a byte |
| rx_in_data | input | 8 | Received byte offered |
| rx_out_valid | output | 1 | Receive queue holds a byte |
| rx_out_ready | input | 1 | Host takes the oldest received byte |
| rx_out_data | output | 8 | Oldest received byte |
| tx_count | output | 5 | Bytes in the transmit queue |
| rx_count | output | 5 | Bytes in the receive queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_trig_hit | output | 1 | Receive count at or above the threshold |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |

## Verification
A control write that empties the receive queue and a receive push can land on the same edge. The bench provokes this by holding `rx_in_valid` high during the flushing write. It judges the outcome by a zero receive count and a released `rx_rdy_n` on the next cycle, and then by a fresh push being accepted. It also provokes a push and a pop on the same edge of a partly filled queue. There it judges that the count holds and that the oldest byte left while the new one joined the tail.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_depth(trig_sel_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  output logic      fifo_en,
  output logic      block_mode,
  output trig_sel_e trig_sel,
  output logic      flush_rx,
  output logic      flush_tx
);
  localparam int EN_BIT   = 0;
  localparam int RXCLR    = 1;
  localparam int TXCLR    = 2;
  localparam int MODE_BIT = 3;
  localparam int TRIG_LO  = 6;
  localparam int TRIG_HI  = 7;

  logic en_flip;
  logic unused_rsvd;

  assign unused_rsvd = ^wr_data[5:4];
  assign en_flip  = wr_en && (wr_data[EN_BIT] != fifo_en);
  assign flush_rx = en_flip || (wr_en && wr_data[EN_BIT] && wr_data[RXCLR]);
  assign flush_tx = en_flip || (wr_en && wr_data[EN_BIT] && wr_data[TXCLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en    <= 1'b0;
      block_mode <= 1'b0;
      trig_sel   <= TRIG_ONE;
    end else if (wr_en) begin
      fifo_en <= wr_data[EN_BIT];
      if (wr_data[EN_BIT]) begin
        block_mode <= wr_data[MODE_BIT];
        trig_sel   <= trig_sel_e'(wr_data[TRIG_HI:TRIG_LO]);
      end
    end
  end

  p_keep_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EN_BIT]) |=> (!fifo_en && $stable(block_mode) && $stable(trig_sel)));

  p_flush_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rx || flush_tx) |-> wr_en);

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   single_mode,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DW-1:0]          in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DW-1:0]          out_data,
  output logic [$clog2(DEPTH):0] count,
  output logic                   empty,
  output logic                   full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          in_fire, out_fire;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty     = (count == '0);
  assign full      = single_mode ? !empty : (count == CW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_ready && out_valid;

  always_ff @(posedge clk) begin
    if (in_fire && !flush) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (in_fire)  wr_ptr <= bump(wr_ptr);
      if (out_fire) rd_ptr <= bump(rd_ptr);
      case ({in_fire, out_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_single_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |-> (count <= CW'(1)));

  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid && !flush) |=> empty);

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          block_mode,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_full,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_level,
  output logic          rx_trig_hit,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n
);
  logic blk;
  logic rx_hold, rx_hold_nxt;

  assign blk         = fifo_en && block_mode;
  assign rx_trig_hit = (rx_count >= rx_level);
  assign rx_hold_nxt = rx_trig_hit || (rx_hold && (rx_count != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_hold <= 1'b0;
    else        rx_hold <= rx_hold_nxt;
  end

  assign tx_rdy_n = blk ? tx_full : (tx_count != '0);
  assign rx_rdy_n = blk ? !rx_hold_nxt : (rx_count == '0);

  p_blk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !rx_rdy_n) |=> (!blk || (rx_count == '0) || !rx_rdy_n));

  p_trig_requests_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && rx_trig_hit) |-> !rx_rdy_n);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [7:0]             cfg_wdata,
  input  logic                   tx_in_valid,
  output logic                   tx_in_ready,
  input  logic [DW-1:0]          tx_in_data,
  output logic                   tx_out_valid,
  input  logic                   tx_out_ready,
  output logic [DW-1:0]          tx_out_data,
  input  logic                   rx_in_valid,
  output logic                   rx_in_ready,
  input  logic [DW-1:0]          rx_in_data,
  output logic                   rx_out_valid,
  input  logic                   rx_out_ready,
  output logic [DW-1:0]          rx_out_data,
  output logic [$clog2(DEPTH):0] tx_count,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic                   tx_empty,
  output logic                   tx_full,
  output logic                   rx_empty,
  output logic                   rx_full,
  output logic                   rx_trig_hit,
  output logic                   tx_rdy_n,
  output logic                   rx_rdy_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic      fifo_en, block_mode, flush_rx, flush_tx;
  trig_sel_e trig_sel;
  logic [CW-1:0] rx_level;

  assign rx_level = CW'(trig_depth(trig_sel));

  uart_fifo_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .fifo_en    (fifo_en),
    .block_mode (block_mode),
    .trig_sel   (trig_sel),
    .flush_rx   (flush_rx),
    .flush_tx   (flush_tx)
  );

  uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush_tx),
    .single_mode (!fifo_en),
    .in_valid    (tx_in_valid),
    .in_ready    (tx_in_ready),
    .in_data     (tx_in_data),
    .out_valid   (tx_out_valid),
    .out_ready   (tx_out_ready),
    .out_data    (tx_out_data),
    .count       (tx_count),
    .empty       (tx_empty),
    .full        (tx_full)
  );

  uart_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush_rx),
    .single_mode (!fifo_en),
    .in_valid    (rx_in_valid),
    .in_ready    (rx_in_ready),
    .in_data     (rx_in_data),
    .out_valid   (rx_out_valid),
    .out_ready   (rx_out_ready),
    .out_data    (rx_out_data),
    .count       (rx_count),
    .empty       (rx_empty),
    .full        (rx_full)
  );

  uart_fifo_dma #(.CW(CW)) u_dma (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .block_mode  (block_mode),
    .tx_count    (tx_count),
    .tx_full     (tx_full),
    .rx_count    (rx_count),
    .rx_level    (rx_level),
    .rx_trig_hit (rx_trig_hit),
    .tx_rdy_n    (tx_rdy_n),
    .rx_rdy_n    (rx_rdy_n)
  );

endmodule

// File: tb/uart_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = 8'h00, rx_in_data = 8'h00;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [4:0] tx_count, rx_count;
  logic tx_empty, tx_full, rx_empty, rx_full, rx_trig_hit, tx_rdy_n, rx_rdy_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] dval = 8'h10;

  always #4 clk = ~clk;

  uart_fifo_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_count(tx_count), .rx_count(rx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_trig_hit(rx_trig_hit),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] cdat;
    logic       rx_push;
    logic       rx_pop;
    logic       tx_push;
    logic       tx_pop;
    logic [4:0] reps;
    logic [4:0] e_rx;
    logic [4:0] e_tx;
    logic       e_rxn;
    logic       e_txn;
    logic       e_trig;
  } vec_t;

  localparam int NV = 25;
  // fields: wr, cdat, rx_push, rx_pop, tx_push, tx_pop, reps, e_rx, e_tx, e_rxn, e_txn, e_trig
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd1,  5'd0,  1'b0, 1'b0, 1'b1}, // R6 single rx
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd1,  5'd0,  1'b0, 1'b0, 1'b1}, // R6 second dropped
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1,  5'd1,  5'd1,  1'b0, 1'b1, 1'b1}, // R9 tx not empty
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1,  5'd1,  5'd1,  1'b0, 1'b1, 1'b1}, // R6 tx single
    '{1'b1, 8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R4 enable flushes
    '{1'b1, 8'hC9, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R2 thr 14 block
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13, 5'd13, 5'd0,  1'b1, 1'b0, 1'b0}, // R11 below thr
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd14, 5'd0,  1'b0, 1'b0, 1'b1}, // R11 reach thr
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2,  5'd16, 5'd0,  1'b0, 1'b0, 1'b1}, // R5 fill past thr
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd16, 5'd0,  1'b0, 1'b0, 1'b1}, // R5 overflow drop
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd15, 5'd1,  5'd0,  1'b0, 1'b0, 1'b0}, // R11 hysteresis
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R11 release
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R7 empty pop
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd15, 5'd0,  5'd15, 1'b1, 1'b0, 1'b0}, // R10 free slot
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1,  5'd0,  5'd16, 1'b1, 1'b1, 1'b0}, // R10 full
    '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R2 R4 disable
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd1,  5'd0,  1'b0, 1'b0, 1'b0}, // R2 R8 thr 14 kept
    '{1'b1, 8'h47, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0}, // R4 thr 4 mode 0
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3,  5'd3,  5'd0,  1'b0, 1'b0, 1'b0}, // R9 rx per-char
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd4,  5'd0,  1'b0, 1'b0, 1'b1}, // R8 thr 4
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2,  5'd4,  5'd2,  1'b0, 1'b1, 1'b1}, // R9 tx
    '{1'b1, 8'h43, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0,  5'd2,  1'b1, 1'b1, 1'b0}, // R3 rx flush
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd1,  5'd2,  1'b0, 1'b1, 1'b0}, // R3 self-clear
    '{1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1,  5'd1,  5'd0,  1'b0, 1'b0, 1'b0}, // R3 tx flush
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1,  5'd1,  5'd1,  1'b0, 1'b1, 1'b0}  // R3 self-clear
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cfg_wr = 1'b0; rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] v);
    rx_in_valid = 1'b1; rx_in_data = v;
    tick();
    rx_in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_rdy_n", tx_rdy_n, 0);
    chk("R1 rx_rdy_n", rx_rdy_n, 1);
    chk("R1 rx_out_valid", rx_out_valid, 0);

    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < int'(TBL[i].reps); r++) begin
        cfg_wr = TBL[i].wr; cfg_wdata = TBL[i].cdat;
        rx_in_valid = TBL[i].rx_push; rx_out_ready = TBL[i].rx_pop;
        tx_in_valid = TBL[i].tx_push; tx_out_ready = TBL[i].tx_pop;
        rx_in_data = dval; tx_in_data = dval; dval = dval + 8'd1;
        tick();
      end
      idle_inputs();
      chk($sformatf("R5 R6 rx count row %0d", i), rx_count, TBL[i].e_rx);
      chk($sformatf("R5 R6 tx count row %0d", i), tx_count, TBL[i].e_tx);
      chk($sformatf("R9 R11 rx_rdy_n row %0d", i), rx_rdy_n, TBL[i].e_rxn);
      chk($sformatf("R9 R10 tx_rdy_n row %0d", i), tx_rdy_n, TBL[i].e_txn);
      chk($sformatf("R8 trig row %0d", i), rx_trig_hit, TBL[i].e_trig);
    end

    // R5 R12 order with a simultaneous push and pop
    cfg_write(8'h07);
    chk("R3 both flushed", rx_count + tx_count, 0);
    for (int k = 0; k < 5; k++) rx_push(8'hA0 + 8'(k));
    chk("R5 head", rx_out_data, 8'hA0);
    rx_in_valid = 1'b1; rx_in_data = 8'hA5; rx_out_ready = 1'b1;
    tick();
    idle_inputs();
    chk("R12 push+pop count", rx_count, 5);
    for (int k = 1; k <= 5; k++) begin
      chk("R5 R12 order", rx_out_data, 8'hA0 + k);
      rx_out_ready = 1'b1;
      tick();
      rx_out_ready = 1'b0;
    end
    chk("R7 drained", rx_out_valid, 0);

    // R5 tx order
    for (int k = 0; k < 3; k++) begin
      tx_in_valid = 1'b1; tx_in_data = 8'hC0 + 8'(k);
      tick();
    end
    tx_in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R5 tx order", tx_out_data, 8'hC0 + k);
      tx_out_ready = 1'b1;
      tick();
      tx_out_ready = 1'b0;
    end
    chk("R9 tx empty again", tx_rdy_n, 0);

    // R12 flush and push on the same edge
    rx_push(8'h55);
    rx_push(8'h56);
    cfg_wr = 1'b1; cfg_wdata = 8'h03; rx_in_valid = 1'b1; rx_in_data = 8'h57;
    tick();
    idle_inputs();
    chk("R12 flush beats push", rx_count, 0);
    chk("R12 rx_rdy_n released", rx_rdy_n, 1);
    rx_push(8'h58);
    chk("R3 push after flush", rx_count, 1);
    chk("R3 value after flush", rx_out_data, 8'h58);

    // R5 full queue drops further pushes
    cfg_write(8'h03);
    for (int k = 0; k < 16; k++) rx_push(8'h20 + 8'(k));
    chk("R5 full flag", rx_full, 1);
    chk("R5 in_ready low", rx_in_ready, 0);
    rx_push(8'hEE);
    chk("R5 count held", rx_count, 16);
    chk("R5 oldest kept", rx_out_data, 8'h20);

    // R7 pop from empty
    cfg_write(8'h03);
    rx_out_ready = 1'b1;
    tick();
    rx_out_ready = 1'b0;
    chk("R7 count after empty pop", rx_count, 0);
    chk("R7 out_valid", rx_out_valid, 0);

    // R8 threshold of 8
    cfg_write(8'h83);
    for (int k = 0; k < 7; k++) rx_push(8'h30 + 8'(k));
    chk("R8 seven below eight", rx_trig_hit, 0);
    rx_push(8'h37);
    chk("R8 eight reached", rx_trig_hit, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule